// File: doc/BRIEF.md
# I2C Multi-Master Arbitration Guard

This block sits beside an I2C master's byte engine and decides whether that master may use the bus and whether it still owns it. It watches the already-synchronized SCL and SDA lines and finds START and STOP conditions. From these it keeps a bus-busy state. A request to begin a transfer is granted only while the bus is idle. A request made while another master holds the bus waits until a STOP returns the bus to idle.

While the local master is sending, the block compares the bit the master wants on SDA with the level actually on the wire. It does this once per bit, on the first sample after SCL rises. The check covers address and data bits alike. If the master releases SDA (wants a 1) but the wire reads 0, another master has won. The block then raises a one-cycle loss pulse and sets a sticky loss flag that software clears. It also forces the master's SDA driver off until the bus next goes idle. Bits sampled while the master is not transmitting, such as the acknowledge slot of a read, are never compared.

Top module: `i2c_arb_guard`

## Requirements
- R1: After reset, bus_busy_o, start_grant_o, arb_lost_pulse_o, arb_lost_flag_o and drv_off_o are all 0.
- R2: SDA falling from 1 to 0 on two consecutive samples with SCL 1 on both (a START) sets bus_busy_o to 1 one clock edge after the sample that shows SDA low.
- R3: SDA rising from 0 to 1 on two consecutive samples with SCL 1 on both (a STOP) clears bus_busy_o to 0 one clock edge after the sample that shows SDA high.
- R4: SDA changes made while SCL is 0 leave bus_busy_o unchanged.
- R5: A start_req_i pulse while bus_busy_o is 0 gives exactly one start_grant_o cycle, one edge after the request. A grant is never issued while bus_busy_o is 1.
- R6: A start_req_i pulse while bus_busy_o is 1 is remembered with no grant. One edge after bus_busy_o falls, start_grant_o is 1 for one cycle.
- R7: Suppose tx_active_i is 1, sda_drive_i is 1 (released) and sda_i is 0 on the first sample with SCL 1 after a sample with SCL 0. Then arb_lost_pulse_o is 1 for exactly one cycle, one edge later.
- R8: A bit whose sda_i equals sda_drive_i at that first high sample gives no loss, in address and data bits alike. Later samples in the same SCL high phase are never compared.
- R9: When tx_active_i is 0 at the SCL rise sample, no comparison is made and no loss is reported.
- R10: drv_off_o rises together with the loss pulse. It stays 1 through later bits and falls one edge after a STOP, together with bus_busy_o.
- R11: arb_lost_flag_o rises with the loss pulse and stays 1 until lost_clr_i is 1 at an edge. While drv_off_o is 1, no further loss pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| sda_drive_i | input | 1 | Bit the master intends on SDA (1 = released) |
| tx_active_i | input | 1 | Master is currently sending bits on SDA |
| start_req_i | input | 1 | Request to begin a transfer |
| lost_clr_i | input | 1 | Software clear of the sticky loss flag |
| bus_busy_o | output | 1 | Bus held between START and STOP |
| start_grant_o | output | 1 | One-cycle permission to issue START |
| arb_lost_pulse_o | output | 1 | One-cycle arbitration-loss indication |
| arb_lost_flag_o | output | 1 | Sticky arbitration-loss flag |
| drv_off_o | output | 1 | Forces the master's SDA driver off |

## Verification
Every result is a register fed straight from the sampled inputs plus one stored line sample. So bus_busy_o, the loss pulse, the loss flag and drv_off_o are due one edge after the sample that completes the condition. A grant is due one edge after a request while idle. For a request that waited, the grant comes one edge after bus_busy_o falls. The bench changes inputs just after a falling clock edge. It reads outputs at the next falling edge, which lies exactly one rising edge later. For the delayed grant it reads twice: first that the grant is still 0 when idle appears, then that it is 1 one cycle on. Each loss test also holds SCL high for an extra sample, to show that the pulse falls and is not repeated.

// File: rtl/i2c_arb_pkg.sv
`timescale 1ns/1ps
package i2c_arb_pkg;

    // one sample of the two bus wires
    typedef struct packed {
        logic scl;
        logic sda;
    } line_smp_t;

    // conditions found between two consecutive samples
    typedef struct packed {
        logic start_seen;
        logic stop_seen;
        logic scl_rise;
    } bus_evt_t;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_HELD = 1'b1
    } bus_state_e;

    // state of the bus lines when nobody drives them
    localparam line_smp_t LINE_RELEASED = '{scl: 1'b1, sda: 1'b1};

    function automatic logic is_start(input line_smp_t prev, input line_smp_t cur);
        return prev.scl & cur.scl & prev.sda & ~cur.sda;
    endfunction

    function automatic logic is_stop(input line_smp_t prev, input line_smp_t cur);
        return prev.scl & cur.scl & ~prev.sda & cur.sda;
    endfunction

    function automatic logic is_rise(input line_smp_t prev, input line_smp_t cur);
        return ~prev.scl & cur.scl;
    endfunction

    // the wire reads low although this master released it
    function automatic logic bit_overridden(input logic wanted, input logic seen);
        return wanted & ~seen;
    endfunction

endpackage

// File: rtl/i2c_line_tracker.sv
`timescale 1ns/1ps
module i2c_line_tracker
    import i2c_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o,
    output logic     busy_o
);

    line_smp_t  cur_smp;
    line_smp_t  prev_q;
    bus_state_e state_q;
    bus_state_e state_d;

    assign cur_smp = '{scl: scl_i, sda: sda_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= LINE_RELEASED;
        end else begin
            prev_q <= cur_smp;
        end
    end

    always_comb begin
        evt_o.start_seen = is_start(prev_q, cur_smp);
        evt_o.stop_seen  = is_stop(prev_q, cur_smp);
        evt_o.scl_rise   = is_rise(prev_q, cur_smp);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (evt_o.start_seen) state_d = BUS_HELD;
            BUS_HELD: if (evt_o.stop_seen)  state_d = BUS_IDLE;
            default:                        state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign busy_o = (state_q == BUS_HELD);

    // R2: a START on the lines makes the bus busy
    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        (scl_i && $past(scl_i) && $past(sda_i) && !sda_i) |=> busy_o);

    // R3: a STOP on the lines makes the bus idle
    a_r3_stop_idle: assert property (@(posedge clk) disable iff (rst)
        (scl_i && $past(scl_i) && !$past(sda_i) && sda_i) |=> !busy_o);

    // R4: with SCL low the bus state holds
    a_r4_low_hold: assert property (@(posedge clk) disable iff (rst)
        (!scl_i) |=> $stable(busy_o));

    // R2, R3: a START and a STOP can never both be seen at one edge
    a_r2_evt_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(evt_o.start_seen && evt_o.stop_seen));

endmodule

// File: rtl/i2c_start_gate.sv
`timescale 1ns/1ps
module i2c_start_gate (
    input  logic clk,
    input  logic rst,
    input  logic busy_i,
    input  logic start_seen_i,
    input  logic req_i,
    output logic grant_o
);

    logic pend_q;
    logic grant_q;
    logic want;
    logic grant_d;

    assign want    = req_i | pend_q;
    // no grant while the bus is held, while another START is on the
    // wire at this edge, or in the cycle right after a grant
    assign grant_d = want & ~busy_i & ~start_seen_i & ~grant_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            grant_q <= 1'b0;
        end else begin
            pend_q  <= grant_d ? 1'b0 : want;
            grant_q <= grant_d;
        end
    end

    assign grant_o = grant_q;

    // R5: a grant only appears on an idle bus
    a_r5_grant_idle: assert property (@(posedge clk) disable iff (rst)
        grant_o |-> !busy_i);

    // R5: a grant lasts one cycle
    a_r5_grant_single: assert property (@(posedge clk) disable iff (rst)
        grant_o |=> !grant_o);

    // R6: a request on a held bus is not granted at the next edge
    a_r6_held_off: assert property (@(posedge clk) disable iff (rst)
        (req_i && busy_i) |=> !grant_o);

endmodule

// File: rtl/i2c_arb_compare.sv
`timescale 1ns/1ps
module i2c_arb_compare
    import i2c_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic scl_rise_i,
    input  logic stop_seen_i,
    input  logic tx_active_i,
    input  logic sda_drive_i,
    input  logic sda_i,
    input  logic clr_i,
    output logic pulse_o,
    output logic flag_o,
    output logic drv_off_o
);

    logic pulse_q;
    logic flag_q;
    logic off_q;
    logic lose_now;

    // one comparison per bit, only while sending and still driving
    assign lose_now = scl_rise_i & tx_active_i & ~off_q
                    & bit_overridden(sda_drive_i, sda_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
            flag_q  <= 1'b0;
            off_q   <= 1'b0;
        end else begin
            pulse_q <= lose_now;
            flag_q  <= lose_now | (flag_q & ~clr_i);
            if (lose_now) begin
                off_q <= 1'b1;
            end else if (stop_seen_i) begin
                off_q <= 1'b0;
            end
        end
    end

    assign pulse_o   = pulse_q;
    assign flag_o    = flag_q;
    assign drv_off_o = off_q;

    // R7: the loss pulse lasts one cycle
    a_r7_pulse_single: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);

    // R10, R11: a loss pulse comes with the flag and the driver shut off
    a_r10_pulse_side: assert property (@(posedge clk) disable iff (rst)
        pulse_o |-> (flag_o && drv_off_o));

    // R9: no loss unless the master was sending
    a_r9_idle_tx: assert property (@(posedge clk) disable iff (rst)
        !tx_active_i |=> !pulse_o);

    // R10: the driver stays off until a STOP
    a_r10_off_hold: assert property (@(posedge clk) disable iff (rst)
        (drv_off_o && !stop_seen_i) |=> drv_off_o);

    // R11: the sticky flag holds until cleared
    a_r11_flag_hold: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o);

    // R11: no second pulse while the driver is off
    a_r11_no_repeat: assert property (@(posedge clk) disable iff (rst)
        drv_off_o |=> !pulse_o);

endmodule

// File: rtl/i2c_arb_guard.sv
`timescale 1ns/1ps
module i2c_arb_guard
    import i2c_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic sda_drive_i,
    input  logic tx_active_i,
    input  logic start_req_i,
    input  logic lost_clr_i,
    output logic bus_busy_o,
    output logic start_grant_o,
    output logic arb_lost_pulse_o,
    output logic arb_lost_flag_o,
    output logic drv_off_o
);

    bus_evt_t evt;
    logic     busy;

    i2c_line_tracker u_track (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_i),
        .sda_i  (sda_i),
        .evt_o  (evt),
        .busy_o (busy)
    );

    i2c_start_gate u_gate (
        .clk          (clk),
        .rst          (rst),
        .busy_i       (busy),
        .start_seen_i (evt.start_seen),
        .req_i        (start_req_i),
        .grant_o      (start_grant_o)
    );

    i2c_arb_compare u_cmp (
        .clk         (clk),
        .rst         (rst),
        .scl_rise_i  (evt.scl_rise),
        .stop_seen_i (evt.stop_seen),
        .tx_active_i (tx_active_i),
        .sda_drive_i (sda_drive_i),
        .sda_i       (sda_i),
        .clr_i       (lost_clr_i),
        .pulse_o     (arb_lost_pulse_o),
        .flag_o      (arb_lost_flag_o),
        .drv_off_o   (drv_off_o)
    );

    assign bus_busy_o = busy;

    // R10: the driver is off only while the bus is held
    a_r10_off_busy: assert property (@(posedge clk) disable iff (rst)
        drv_off_o |-> bus_busy_o);

endmodule

// File: tb/i2c_arb_guard_bench.sv
`timescale 1ns/1ps
module i2c_arb_guard_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1, sda = 1'b1, drive = 1'b1, tx = 1'b0, req = 1'b0, clr = 1'b0;
    logic busy, grant, pulse, flag, off;
    int   n_chk = 0;
    int   n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    i2c_arb_guard u_i2c_arb_guard (
        .clk              (clk),
        .rst              (rst),
        .scl_i            (scl),
        .sda_i            (sda),
        .sda_drive_i      (drive),
        .tx_active_i      (tx),
        .start_req_i      (req),
        .lost_clr_i       (clr),
        .bus_busy_o       (busy),
        .start_grant_o    (grant),
        .arb_lost_pulse_o (pulse),
        .arb_lost_flag_o  (flag),
        .drv_off_o        (off)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic do_start();
        scl = 1'b1; sda = 1'b1; step();
        sda = 1'b0; step();
        scl = 1'b0; step();
    endtask

    task automatic do_stop();
        scl = 1'b0; sda = 1'b0; step();
        scl = 1'b1; step();
        sda = 1'b1; step();
    endtask

    // one bit; p returns the pulse one edge after the SCL rise sample
    task automatic do_bit(input logic d, input logic s, input logic t, output logic p);
        scl = 1'b0; step();
        sda = s; drive = d; tx = t; step();
        scl = 1'b1; step();
        p = pulse;
        step();
        scl = 1'b0; step();
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 1'b0);
        chk("R1 grant", grant, 1'b0);
        chk("R1 pulse", pulse, 1'b0);
        chk("R1 flag", flag, 1'b0);
        chk("R1 drv_off", off, 1'b0);
    endtask

    task automatic t_start_stop();
        scl = 1'b1; sda = 1'b1; step();
        sda = 1'b0; step();
        chk("R2 busy after START", busy, 1'b1);
        scl = 1'b0; step();
        for (int i = 0; i < 4; i++) begin
            sda = ~sda; step();
            chk("R4 busy held with SCL low", busy, 1'b1);
        end
        sda = 1'b0; step();
        scl = 1'b1; step();
        chk("R3 busy before STOP", busy, 1'b1);
        sda = 1'b1; step();
        chk("R3 idle after STOP", busy, 1'b0);
        // toggle SDA with SCL low on an idle bus
        scl = 1'b0; step();
        sda = 1'b0; step();
        sda = 1'b1; step();
        chk("R4 idle held with SCL low", busy, 1'b0);
        scl = 1'b1; step();
    endtask

    task automatic t_grant_idle();
        req = 1'b1; step();
        req = 1'b0;
        chk("R5 grant on idle", grant, 1'b1);
        step();
        chk("R5 grant one cycle", grant, 1'b0);
        step();
        chk("R5 no second grant", grant, 1'b0);
    endtask

    task automatic t_grant_wait();
        do_start();
        req = 1'b1; step();
        req = 1'b0;
        chk("R6 no grant while busy", grant, 1'b0);
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R6 still held off", grant, 1'b0);
        end
        do_stop();
        chk("R6 idle seen", busy, 1'b0);
        chk("R6 grant not yet", grant, 1'b0);
        step();
        chk("R6 grant after idle", grant, 1'b1);
        step();
        chk("R6 grant one cycle", grant, 1'b0);
    endtask

    task automatic t_win_bits();
        logic p;
        logic [7:0] addr = 8'hA6;
        logic [7:0] data = 8'h3C;
        do_start();
        for (int i = 7; i >= 0; i--) begin
            do_bit(addr[i], addr[i], 1'b1, p);
            chk("R8 address bit matches", p, 1'b0);
        end
        // acknowledge from slave, master not sending
        do_bit(1'b1, 1'b0, 1'b0, p);
        chk("R9 ack slot not compared", p, 1'b0);
        for (int i = 7; i >= 0; i--) begin
            do_bit(data[i], data[i], 1'b1, p);
            chk("R8 data bit matches", p, 1'b0);
        end
        // drive changes to 1 after the rise sample while SDA stays low
        scl = 1'b0; step();
        sda = 1'b0; drive = 1'b0; tx = 1'b1; step();
        scl = 1'b1; step();
        drive = 1'b1; step();
        chk("R8 only first high sample compared", pulse, 1'b0);
        step();
        chk("R8 no late loss", flag, 1'b0);
        scl = 1'b0; step();
        chk("R8 driver still on", off, 1'b0);
        tx = 1'b0;
        do_stop();
    endtask

    task automatic t_read_slot();
        logic p;
        do_start();
        do_bit(1'b1, 1'b0, 1'b0, p);
        chk("R9 no loss when not sending", p, 1'b0);
        chk("R9 flag clear", flag, 1'b0);
        chk("R9 driver on", off, 1'b0);
        do_stop();
    endtask

    task automatic t_lose();
        logic p;
        do_start();
        do_bit(1'b0, 1'b0, 1'b1, p);
        chk("R8 first bit won", p, 1'b0);
        scl = 1'b0; step();
        sda = 1'b0; drive = 1'b1; tx = 1'b1; step();
        scl = 1'b1; step();
        chk("R7 loss pulse", pulse, 1'b1);
        chk("R11 flag set", flag, 1'b1);
        chk("R10 driver off", off, 1'b1);
        step();
        chk("R7 pulse one cycle", pulse, 1'b0);
        scl = 1'b0; step();
        do_bit(1'b1, 1'b0, 1'b1, p);
        chk("R11 no repeat pulse", p, 1'b0);
        chk("R10 driver stays off", off, 1'b1);
        chk("R11 flag sticky", flag, 1'b1);
        tx = 1'b0;
        scl = 1'b0; sda = 1'b0; step();
        scl = 1'b1; step();
        chk("R10 off until STOP", off, 1'b1);
        sda = 1'b1; step();
        chk("R10 driver on after STOP", off, 1'b0);
        chk("R3 idle after STOP", busy, 1'b0);
        chk("R11 flag survives STOP", flag, 1'b1);
        clr = 1'b1; step();
        clr = 1'b0;
        chk("R11 flag cleared", flag, 1'b0);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_start_stop();
        t_grant_idle();
        t_grant_wait();
        t_win_bits();
        t_read_slot();
        t_lose();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule